// File: doc/BRIEF.md
# Compact Floating-Point Adder and Multiplier

This block performs addition or multiplication on a 14-bit floating-point word. Each word holds a sign bit, a 5-bit exponent stored in excess-16, and an 8-bit significand. The significand is a pure fraction with no hidden bit. A nonzero value is normalized, so the top significand bit is 1. The value of a word is `(-1)^s * (sig / 256) * 2^(exp - 16)`.

An operand pair and an operation select are presented with `in_valid`. With the default parameters, the result and two range flags appear in registers one clock later. Addition aligns the smaller operand to the larger exponent, then adds or subtracts the significands, then renormalizes. Multiplication forms the full significand product, sums the true exponents, then renormalizes. Every bit that drops off is truncated.

Top module: `fp14_arith`

## Requirements
- R1: A cycle with `in_valid` high loads `result`, `ovf` and `unf` on the next rising edge, and `out_valid` follows `in_valid` one cycle later. Without `in_valid`, the outputs hold. Reset clears every output to 0.
- R2: An operand with significand 0 is a zero of either sign, whatever its exponent field. Adding a zero returns the other operand unchanged, and adding two zeros returns positive zero (all bits 0).
- R3: Adding two operands of equal sign adds their magnitudes and keeps that sign. When the significand sum carries out, it is shifted right one place, dropping its LSB, and the exponent rises by one.
- R4: Adding operands of opposite sign subtracts the smaller magnitude from the larger. Magnitude is compared on exponent first, then significand. The result takes the sign of the larger and is shifted left until its significand MSB (bit 7) is 1, with the exponent lowered by one per place.
- R5: Any result whose exact value is zero, such as a value plus its negation, is output as positive zero with no flag.
- R6: During alignment, the smaller operand's significand is shifted right by the exponent difference and its low bits are discarded. A difference of 8 or more leaves it at 0.
- R7: For a product, the sign is the XOR of the operand signs. The 16-bit significand product is normalized so that its top one bit lands in bit 7 of the result significand. The stored exponent is `ea + eb - 16`, less one if bit 15 of the product is 0.
- R8: When the normalized stored exponent would exceed 31, `ovf` is set. The result saturates to the operand-derived sign with the exponent at 31 and the significand at 0xFF.
- R9: When the normalized stored exponent would fall below 0, `unf` is set and the result is positive zero.
- R10: A product with a zero operand is positive zero with no flag.
- R11: Every nonzero result has bit 7 of the significand set. `ovf` and `unf` are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_sel | input | 1 | 0 selects addition, 1 selects multiplication |
| opa | input | 14 | First operand: sign[13], exponent[12:8], significand[7:0] |
| opb | input | 14 | Second operand, same layout |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| result | output | 14 | Normalized result word |
| ovf | output | 1 | Exponent overflow, result saturated |
| unf | output | 1 | Exponent underflow, result forced to zero |

## Verification
The bench builds the block with its defaults: 5 exponent bits, 8 significand bits, a bias of 16 and the registered output. With only 14 bits, directed vectors can reach each range edge. Examples are a carry out of exponent 31 and a one-bit difference at exponent 0 that needs seven left shifts. Products of two large or two small exponents drive the flags from both sides. Random normalized operands across the whole exponent range exercise alignment shifts of 0 through 31, including every shift that empties the smaller significand.

// File: rtl/fp14_pkg.sv
package fp14_pkg;
   typedef enum logic {
      FP_OP_ADD = 1'b0,
      FP_OP_MUL = 1'b1
   } fp_op_e;

   // width of the signed working exponent: room for sum of two stored
   // exponents and for the largest normalization shift
   function automatic int work_exp_w(input int exp_w);
      return exp_w + 3;
   endfunction
endpackage

// File: rtl/fp14_addcore.sv
module fp14_addcore #(
   parameter int EXP_W = 5,
   parameter int SIG_W = 8,
   parameter int EW    = EXP_W + 3
) (
   input  logic                 a_sign,
   input  logic [EXP_W-1:0]     a_exp,
   input  logic [SIG_W-1:0]     a_sig,
   input  logic                 b_sign,
   input  logic [EXP_W-1:0]     b_exp,
   input  logic [SIG_W-1:0]     b_sig,
   output logic                 r_sign,
   output logic signed [EW-1:0] r_exp,
   output logic [2*SIG_W-1:0]   r_man
);
   localparam int MW = 2 * SIG_W;

   logic             a_big;
   logic [EXP_W-1:0] big_exp, small_exp, shift_amt;
   logic [SIG_W-1:0] big_sig, small_sig, aligned;
   logic             big_sign;
   logic [SIG_W:0]   sum;
   logic [SIG_W-1:0] diff;

   // magnitude order: exponent first, significand second
   assign a_big = {a_exp, a_sig} >= {b_exp, b_sig};

   always_comb begin
      if (a_big) begin
         big_exp   = a_exp;  big_sig   = a_sig;  big_sign = a_sign;
         small_exp = b_exp;  small_sig = b_sig;
      end else begin
         big_exp   = b_exp;  big_sig   = b_sig;  big_sign = b_sign;
         small_exp = a_exp;  small_sig = a_sig;
      end
   end

   assign shift_amt = big_exp - small_exp;
   assign aligned   = small_sig >> shift_amt;
   assign sum       = {1'b0, big_sig} + {1'b0, aligned};
   assign diff      = big_sig - aligned;

   always_comb begin
      r_sign = big_sign;
      if (a_sign == b_sign) begin
         // sum has one extra integer bit: frame it one place higher
         r_man = {sum, {(MW-SIG_W-1){1'b0}}};
         r_exp = EW'(big_exp) + EW'(1);
      end else begin
         r_man = {diff, {(MW-SIG_W){1'b0}}};
         r_exp = EW'(big_exp);
      end
   end
endmodule

// File: rtl/fp14_mulcore.sv
module fp14_mulcore #(
   parameter int EXP_W = 5,
   parameter int SIG_W = 8,
   parameter int BIAS  = 16,
   parameter int EW    = EXP_W + 3
) (
   input  logic                 a_sign,
   input  logic [EXP_W-1:0]     a_exp,
   input  logic [SIG_W-1:0]     a_sig,
   input  logic                 b_sign,
   input  logic [EXP_W-1:0]     b_exp,
   input  logic [SIG_W-1:0]     b_sig,
   output logic                 r_sign,
   output logic signed [EW-1:0] r_exp,
   output logic [2*SIG_W-1:0]   r_man
);
   localparam int MW = 2 * SIG_W;

   assign r_sign = a_sign ^ b_sign;
   assign r_man  = MW'(a_sig) * MW'(b_sig);
   // product of two fractions is a fraction of MW bits: stored exponent
   // is the sum of true exponents re-biased once
   assign r_exp  = EW'(a_exp) + EW'(b_exp) - EW'(BIAS);
endmodule

// File: rtl/fp14_norm.sv
module fp14_norm #(
   parameter int EXP_W = 5,
   parameter int SIG_W = 8,
   parameter int EW    = EXP_W + 3
) (
   input  logic                       n_sign,
   input  logic signed [EW-1:0]       n_exp,
   input  logic [2*SIG_W-1:0]         n_man,
   output logic [EXP_W+SIG_W:0]       n_word,
   output logic                       n_ovf,
   output logic                       n_unf
);
   localparam int MW  = 2 * SIG_W;
   localparam int LZW = $clog2(MW + 1);
   localparam logic signed [EW-1:0] EMAX = EW'((1 << EXP_W) - 1);

   logic [LZW-1:0]        lead;
   logic [MW-1:0]         shifted;
   logic signed [EW-1:0]  fin_exp;
   logic                  nonzero;

   always_comb begin
      lead = LZW'(MW);
      for (int i = 0; i < MW; i++) begin
         if (n_man[i]) lead = LZW'(MW - 1 - i);
      end
   end

   assign nonzero = |n_man;
   assign shifted = n_man << lead;
   assign fin_exp = n_exp - EW'(lead);
   assign n_unf   = nonzero && fin_exp[EW-1];
   assign n_ovf   = nonzero && !fin_exp[EW-1] && (fin_exp > EMAX);

   always_comb begin
      if (!nonzero || n_unf)
         n_word = '0;
      else if (n_ovf)
         n_word = {n_sign, {EXP_W{1'b1}}, {SIG_W{1'b1}}};
      else
         n_word = {n_sign, fin_exp[EXP_W-1:0], shifted[MW-1 -: SIG_W]};
   end
endmodule

// File: rtl/fp14_arith.sv
module fp14_arith #(
   parameter int EXP_W   = 5,
   parameter int SIG_W   = 8,
   parameter int BIAS    = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   op_sel,
   input  logic [EXP_W+SIG_W:0]   opa,
   input  logic [EXP_W+SIG_W:0]   opb,
   output logic                   out_valid,
   output logic [EXP_W+SIG_W:0]   result,
   output logic                   ovf,
   output logic                   unf
);
   import fp14_pkg::*;

   localparam int W  = 1 + EXP_W + SIG_W;
   localparam int EW = work_exp_w(EXP_W);
   localparam int MW = 2 * SIG_W;

   generate
      if (EXP_W < 2 || EXP_W > 12) begin : g_bad_exp
         $error("fp14_arith: EXP_W out of range");
      end
      if (SIG_W < 2 || SIG_W > 24) begin : g_bad_sig
         $error("fp14_arith: SIG_W out of range");
      end
      if (BIAS < 1 || BIAS >= (1 << EXP_W)) begin : g_bad_bias
         $error("fp14_arith: BIAS outside exponent range");
      end
   endgenerate

   // operand unpack: a zero significand makes the whole operand zero
   logic [W-1:0]     ops [2];
   logic             u_sign [2];
   logic [EXP_W-1:0] u_exp  [2];
   logic [SIG_W-1:0] u_sig  [2];

   assign ops[0] = opa;
   assign ops[1] = opb;

   for (genvar k = 0; k < 2; k++) begin : g_unpack
      logic is_zero;
      assign is_zero  = ~|ops[k][SIG_W-1:0];
      assign u_sign[k] = ops[k][W-1];
      assign u_exp[k]  = is_zero ? '0 : ops[k][W-2 -: EXP_W];
      assign u_sig[k]  = ops[k][SIG_W-1:0];
   end

   logic                 add_sign, mul_sign, sel_sign;
   logic signed [EW-1:0] add_exp, mul_exp, sel_exp;
   logic [MW-1:0]        add_man, mul_man, sel_man;

   fp14_addcore #(.EXP_W(EXP_W), .SIG_W(SIG_W), .EW(EW)) u_add (
      .a_sign(u_sign[0]), .a_exp(u_exp[0]), .a_sig(u_sig[0]),
      .b_sign(u_sign[1]), .b_exp(u_exp[1]), .b_sig(u_sig[1]),
      .r_sign(add_sign),  .r_exp(add_exp),  .r_man(add_man)
   );

   fp14_mulcore #(.EXP_W(EXP_W), .SIG_W(SIG_W), .BIAS(BIAS), .EW(EW)) u_mul (
      .a_sign(u_sign[0]), .a_exp(u_exp[0]), .a_sig(u_sig[0]),
      .b_sign(u_sign[1]), .b_exp(u_exp[1]), .b_sig(u_sig[1]),
      .r_sign(mul_sign),  .r_exp(mul_exp),  .r_man(mul_man)
   );

   always_comb begin
      if (fp_op_e'(op_sel) == FP_OP_MUL) begin
         sel_sign = mul_sign; sel_exp = mul_exp; sel_man = mul_man;
      end else begin
         sel_sign = add_sign; sel_exp = add_exp; sel_man = add_man;
      end
   end

   logic [W-1:0] nrm_word;
   logic         nrm_ovf, nrm_unf;

   fp14_norm #(.EXP_W(EXP_W), .SIG_W(SIG_W), .EW(EW)) u_norm (
      .n_sign(sel_sign), .n_exp(sel_exp), .n_man(sel_man),
      .n_word(nrm_word), .n_ovf(nrm_ovf), .n_unf(nrm_unf)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               result    <= '0;
               ovf       <= 1'b0;
               unf       <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  result <= nrm_word;
                  ovf    <= nrm_ovf;
                  unf    <= nrm_unf;
               end
            end
         end

         AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);                                              // R1
         AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(result)));                       // R1
         AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (result[SIG_W-1:0] == '0) |-> (result == '0));                        // R5
         AST_OVF_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
            ovf |-> (result[W-2:0] == {(W-1){1'b1}}));                            // R8
         AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            unf |-> (result == '0));                                              // R9
         AST_NORMALIZED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            (result[SIG_W-1:0] != '0) |-> result[SIG_W-1]);                       // R11
         AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(ovf && unf));                                                       // R11
      end else begin : g_comb
         assign out_valid = in_valid;
         assign result    = nrm_word;
         assign ovf       = nrm_ovf;
         assign unf       = nrm_unf;
      end
   endgenerate
endmodule

// File: tb/tb_fp14_arith.sv
module tb_fp14_arith;
   localparam int W = 14;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic         op_sel;
   logic [W-1:0] opa, opb;
   logic         out_valid;
   logic [W-1:0] result;
   logic         ovf, unf;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   fp14_arith dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
      .ovf(ovf), .unf(unf)
   );

   // behavioural reference: returns {ovf, unf, word}
   function automatic logic [W+1:0] model(input logic mul, input logic [W-1:0] a,
                                          input logic [W-1:0] b);
      int sa, ea, ma, sb, eb, mb, sl, el, ml, es, ms, m, f, e, s, d;
      sa = a[13]; ea = a[12:8]; ma = a[7:0];
      sb = b[13]; eb = b[12:8]; mb = b[7:0];
      if (ma == 0) ea = 0;
      if (mb == 0) eb = 0;
      if (mul) begin
         if (ma == 0 || mb == 0) return '0;
         s = sa ^ sb; m = ma * mb; f = 16; e = ea + eb - 16;
      end else begin
         if (ea * 256 + ma >= eb * 256 + mb) begin
            sl = sa; el = ea; ml = ma; es = eb; ms = mb;
         end else begin
            sl = sb; el = eb; ml = mb; es = ea; ms = ma;
         end
         d  = el - es;
         ms = (d >= 8) ? 0 : (ms >> d);
         m  = (sa == sb) ? ml + ms : ml - ms;
         f = 8; e = el; s = sl;
      end
      if (m == 0) return '0;
      while (m >= (1 << f)) begin m = m >> 1; e = e + 1; end
      while (m < (1 << (f - 1))) begin m = m << 1; e = e - 1; end
      m = m >> (f - 8);
      if (e > 31) return {1'b1, 1'b0, s[0], 5'h1f, 8'hff};
      if (e < 0)  return {1'b0, 1'b1, 14'h0};
      return {2'b00, s[0], e[4:0], m[7:0]};
   endfunction

   task automatic check(input string tag, input logic [W+1:0] exp_v, input logic exp_vld);
      checks++;
      if ({ovf, unf, result} !== exp_v || out_valid !== exp_vld) begin
         errors++;
         $display("FAIL %s: got vld=%0b ovf=%0b unf=%0b res=%h, expected vld=%0b ovf=%0b unf=%0b res=%h",
                  tag, out_valid, ovf, unf, result, exp_vld, exp_v[W+1], exp_v[W], exp_v[W-1:0]);
      end
   endtask

   logic [W+1:0] last_exp = '0;

   // called at a falling edge; checks one cycle later
   task automatic apply(input string tag, input logic mul, input logic [W-1:0] a,
                        input logic [W-1:0] b);
      in_valid = 1'b1; op_sel = mul; opa = a; opb = b;
      last_exp = model(mul, a, b);
      @(negedge clk);
      check(tag, last_exp, 1'b1);
   endtask

   task automatic idle(input string tag);
      in_valid = 1'b0; opa = 14'h3fff; opb = 14'h3fff; op_sel = 1'b1;
      @(negedge clk);
      check(tag, last_exp, 1'b0);
   endtask

   function automatic string rand_tag(input logic mul, input logic [W-1:0] a,
                                      input logic [W-1:0] b);
      logic [W+1:0] v;
      v = model(mul, a, b);
      if (v[W+1]) return "R8";
      if (v[W])   return "R9";
      if (mul)    return "R7";
      return (a[13] == b[13]) ? "R3" : "R4";
   endfunction

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; op_sel = 1'b0; opa = '0; opb = '0;
      repeat (3) @(negedge clk);
      check("R1 reset", '0, 1'b0);
      rst_n = 1'b1;

      // R3: 12 + 12 = 24 (carry renormalization)
      apply("R3 carry", 1'b0, 14'h14c0, 14'h14c0);
      // R6: alignment by 4 drops low bits of 0xFF
      apply("R6 align trunc", 1'b0, 14'h1480, 14'h10ff);
      // R6: exponent difference >= 8 leaves larger operand unchanged
      apply("R6 far align", 1'b0, 14'h1e90, 14'h1081);
      // R4: opposite signs, smaller first, sign of larger
      apply("R4 sub", 1'b0, 14'h10c1, 14'h3280);
      // R4: deep left normalization
      apply("R4 renorm", 1'b0, 14'h1481, 14'h3480);
      // R5: exact cancellation
      apply("R5 cancel", 1'b0, 14'h15a5, 14'h35a5);
      // R2: positive and negative zero with odd exponent fields
      apply("R2 negzero add", 1'b0, 14'h3f00, 14'h12b3);
      apply("R2 poszero add", 1'b0, 14'h32b3, 14'h0000);
      apply("R2 two zeros", 1'b0, 14'h2000, 14'h3000);
      // R1: idle cycles hold the result
      idle("R1 hold");
      idle("R1 hold2");
      // R7: 12 * 1.25 and sign XOR
      apply("R7 mul", 1'b1, 14'h14c0, 14'h31a0);
      apply("R7 mul minimum", 1'b1, 14'h1080, 14'h1080);
      apply("R7 mul max", 1'b1, 14'h10ff, 14'h30ff);
      // R10: product with zero
      apply("R10 mul zero", 1'b1, 14'h3000, 14'h35c3);
      apply("R10 mul negzero", 1'b1, 14'h15c3, 14'h2a00);
      // R8: overflow from addition and from multiplication
      apply("R8 add ovf", 1'b0, 14'h3fff, 14'h3fff);
      apply("R8 mul ovf", 1'b1, 14'h1fc0, 14'h3f80);
      // R9: underflow from subtraction and from multiplication
      apply("R9 sub unf", 1'b0, 14'h0081, 14'h2080);
      apply("R9 mul unf", 1'b1, 14'h0280, 14'h2280);
      // R8 edge: stored exponent exactly 31 without overflow
      apply("R8 edge31", 1'b0, 14'h1e80, 14'h1e80);
      // R9 edge: stored exponent exactly 0 without underflow
      apply("R9 edge0", 1'b1, 14'h0880, 14'h0980);

      for (int i = 0; i < 800; i++) begin
         logic [W-1:0] ra, rb;
         logic         rm;
         ra = {1'($urandom), 5'($urandom), 1'b1, 7'($urandom)};
         rb = {1'($urandom), 5'($urandom), 1'b1, 7'($urandom)};
         if (($urandom % 16) == 0) ra[7:0] = '0;
         if (($urandom % 32) == 0) rb = ra ^ 14'h2000;
         rm = 1'($urandom);
         apply(rand_tag(rm, ra, rb), rm, ra, rb);
         if (($urandom % 8) == 0) idle("R1 idle");
      end

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule